// File: doc/BRIEF.md
# Instruction-Framed Serial Register Port

This block is the slave side of a serial control port. Through it, a host reads and writes a small bank of configuration registers whose widths differ. The host lowers the active-low chip select and clocks in an 8-bit instruction, most significant bit first. The instruction gives the direction of the access and a 5-bit register address. A data phase follows. Its length in bytes is looked up from the width of the addressed register. When the last data bit has moved, the port goes back at once to expecting another instruction. Several accesses can therefore be chained inside one chip-select window.

The port runs on a fast system clock. It oversamples the serial clock, the chip select and the data input through a two-stage synchronizer, and it acts on the detected edges. Input bits are taken on the detected rising edges of the serial clock. Read data is launched on the detected falling edges. Because only edges are used, the serial clock may idle either low or high. The bidirectional data pin is presented as a split input, output and output enable. A mode input chooses between two-wire reads on the shared pin and three-wire reads on a dedicated output pin. The whole register bank is offered as one flat parallel vector for the rest of the chip.

The controller has three states. `ST_INSTR` collects instruction bits. On the eighth rising edge it moves to `ST_WRITE` when bit 7 is 0, or to `ST_READ` when bit 7 is 1. `ST_WRITE` and `ST_READ` each return to `ST_INSTR` on the final data bit of the phase. Every state returns to `ST_INSTR` whenever chip select is high.

Top module: `spp_serial_port`

## Requirements
- R1: After reset every register holds zero, and `sdio_oe` and `sdo` are low.
- R2: While `cs_n` is low, the first 8 rising serial-clock edges shift in the instruction MSB first. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 4:0 are the address. Bits 6:5 have no effect.
- R3: A write data phase lasts as many bytes as the addressed register has: address 0 has 4 bytes, 1 has 3, 2 has 4, 3 has 2 and 4 has 2. Data is sent MSB first. The register takes the new value only after its final bit is sampled.
- R4: In `bank_q`, register n sits at a bit offset equal to the summed widths of registers 0 to n-1, with its LSB lowest. Register 0 therefore occupies bits 31:0, register 1 bits 55:32, and so on, for a total of 120 bits.
- R5: Once a transaction's data phase ends, the next 8 rising edges in the same chip-select window form a fresh instruction.
- R6: A read returns the register value MSB first. Each bit is launched on a falling serial-clock edge of the data phase, so it is valid before the following rising edge.
- R7: In two-wire mode (`mode_3w` = 0), read data appears on `sdio_o`. `sdio_oe` is high only during a read data phase, and `sdo` stays low.
- R8: In three-wire mode (`mode_3w` = 1), read data appears on `sdo`, and `sdio_oe` stays low throughout.
- R9: Raising `cs_n` abandons a partial transaction. A write that was cut short leaves its register unchanged, and the next access starts with an instruction.
- R10: Addresses 5 to 31 have a one-byte data phase. Writes to them change nothing, and reads of them return zero.
- R11: Behaviour is the same whether the serial clock idles low or high while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | 1 sends read data to `sdo`, 0 to the shared pin |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Input side of the shared data pin |
| sdio_o | output | 1 | Output side of the shared data pin |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo | output | 1 | Dedicated read-data pin for three-wire mode |
| bank_q | output | 120 | Flat register bank contents |

## Verification
Unmapped accesses sit next to mapped ones in a single chip-select window. A port that used a fixed or wrong byte count would fall out of frame and decode data bits as the next instruction, so the following read would come back wrong. A write is aborted after a byte and a half. A design that committed bytes as they arrived would show a half-updated register. Mixed idle levels, two- and three-wire reads, and non-zero ignored instruction bits are drawn at random with a fixed seed. These catch a port that treats the idle-high first falling edge as data, drives the wrong pin, or decodes bits 6:5 into the address.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int NUM_REGS   = 5;
    localparam int ADDR_W     = 5;
    localparam int INSTR_BITS = 8;
    localparam int MAX_BYTES  = 4;
    localparam int MAX_BITS   = MAX_BYTES * 8;
    localparam int CNT_W      = $clog2(MAX_BITS + 1);

    // Byte width of each mapped register; the data phase length follows it.
    function automatic int reg_bytes(input int idx);
        case (idx)
            0:       return 4;
            1:       return 3;
            2:       return 4;
            3:       return 2;
            4:       return 2;
            default: return 1;
        endcase
    endfunction

    // Bit position of a register inside the flat bank vector.
    function automatic int reg_offset(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) begin
            acc += reg_bytes(k) * 8;
        end
        return acc;
    endfunction

    localparam int BANK_BITS = reg_offset(NUM_REGS);

    typedef enum logic [1:0] {
        ST_INSTR = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } port_state_t;

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spp_reg_bank.sv
module spp_reg_bank
    import spp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [MAX_BITS-1:0]  wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [MAX_BITS-1:0]  rdata,
    output logic [CNT_W-1:0]     rbits,
    output logic [BANK_BITS-1:0] bank_q
);

    logic [MAX_BITS-1:0] words [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam int W   = reg_bytes(gi) * 8;
        localparam int OFF = reg_offset(gi);
        logic [W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && waddr == ADDR_W'(gi)) begin
                q <= wdata[W-1:0];
            end
        end

        assign bank_q[OFF +: W] = q;
        assign words[gi]        = MAX_BITS'(q);
    end

    // Read lookup: value and data-phase length; unmapped -> zero, one byte.
    always_comb begin
        rdata = '0;
        rbits = CNT_W'(8);
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == ADDR_W'(i)) begin
                rdata = words[i];
                rbits = CNT_W'(reg_bytes(i) * 8);
            end
        end
    end

    // R10: a write aimed outside the map leaves the bank untouched
    a_r10_unmapped_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= ADDR_W'(NUM_REGS)) |=> $stable(bank_q));

endmodule

// File: rtl/spp_serial_port.sv
module spp_serial_port
    import spp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_3w,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 sdio_i,
    output logic                 sdio_o,
    output logic                 sdio_oe,
    output logic                 sdo,
    output logic [BANK_BITS-1:0] bank_q
);

    localparam int ISR_W = INSTR_BITS - 1;

    // Synchronised serial lines: {data, clock, select}
    logic [2:0] sync_q;
    logic       s_sdio, s_sclk, s_cs_n;
    logic       sclk_d;
    logic       cs_act, rise, fall;

    spp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdio_i, sclk, cs_n}),
        .q     (sync_q)
    );

    assign {s_sdio, s_sclk, s_cs_n} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= s_sclk;
    end

    assign cs_act = ~s_cs_n;
    assign rise   = cs_act &  s_sclk & ~sclk_d;
    assign fall   = cs_act & ~s_sclk &  sclk_d;

    // Controller state
    port_state_t         state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CNT_W-1:0]    phase_bits;
    logic [ISR_W-1:0]    instr_sr;
    logic [ADDR_W-1:0]   cur_addr;
    logic [MAX_BITS-1:0] rx_sr;
    logic [MAX_BITS-1:0] tx_sr;
    logic                dout;

    // Bank interface
    logic [ADDR_W-1:0]   instr_addr;
    logic                instr_rd;
    logic [MAX_BITS-1:0] rd_word;
    logic [CNT_W-1:0]    rd_bits;
    logic                wr_en;
    logic [MAX_BITS-1:0] wr_data;
    logic                last_bit;

    assign instr_addr = {instr_sr[ADDR_W-2:0], s_sdio};
    assign instr_rd   = instr_sr[ISR_W-1];
    assign last_bit   = (bit_cnt == phase_bits - CNT_W'(1));

    spp_reg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (cur_addr),
        .wdata  (wr_data),
        .raddr  (instr_addr),
        .rdata  (rd_word),
        .rbits  (rd_bits),
        .bank_q (bank_q)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_INSTR;
            bit_cnt    <= '0;
            phase_bits <= CNT_W'(8);
            instr_sr   <= '0;
            cur_addr   <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            dout       <= 1'b0;
        end else if (!cs_act) begin
            state   <= ST_INSTR;
            bit_cnt <= '0;
            dout    <= 1'b0;
        end else begin
            unique case (state)
                ST_INSTR: begin
                    if (rise) begin
                        if (bit_cnt == CNT_W'(INSTR_BITS - 1)) begin
                            cur_addr   <= instr_addr;
                            phase_bits <= rd_bits;
                            tx_sr      <= rd_word << (CNT_W'(MAX_BITS) - rd_bits);
                            rx_sr      <= '0;
                            dout       <= 1'b0;
                            bit_cnt    <= '0;
                            state      <= instr_rd ? ST_READ : ST_WRITE;
                        end else begin
                            instr_sr <= {instr_sr[ISR_W-2:0], s_sdio};
                            bit_cnt  <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_WRITE: begin
                    if (rise) begin
                        rx_sr <= {rx_sr[MAX_BITS-2:0], s_sdio};
                        if (last_bit) begin
                            bit_cnt <= '0;
                            state   <= ST_INSTR;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (fall) begin
                        dout  <= tx_sr[MAX_BITS-1];
                        tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
                    end
                    if (rise) begin
                        if (last_bit) begin
                            bit_cnt <= '0;
                            dout    <= 1'b0;
                            state   <= ST_INSTR;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_INSTR;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en   = (state == ST_WRITE) && rise && last_bit;
        wr_data = {rx_sr[MAX_BITS-2:0], s_sdio};
        sdio_oe = (state == ST_READ) && cs_act && !mode_3w;
        sdio_o  = sdio_oe & dout;
        sdo     = (state == ST_READ) && cs_act && mode_3w && dout;
    end

    // R9: a deselected port is back in the instruction phase next cycle
    a_r9_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_INSTR && bit_cnt == '0));

    // R2: the instruction counter never passes the instruction length
    a_r2_instr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTR) |-> (bit_cnt < CNT_W'(INSTR_BITS)));

    // R3: data-phase counter stays inside the looked-up register width
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INSTR) |-> (bit_cnt < phase_bits));

    // R5: the final data bit re-arms the instruction phase
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_INSTR) && rise && last_bit) |=> (state == ST_INSTR && bit_cnt == '0));

    // R7: the shared pin is only turned around straight out of an instruction
    a_r7_oe_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> ($past(state) == ST_INSTR));

endmodule

// File: tb/tb_spp_serial_port.sv
module tb_spp_serial_port;
    import spp_pkg::*;

    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_3w = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo;
    logic [BANK_BITS-1:0] bank_q;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [5];
    logic idle_hi = 1'b0;

    always #10 clk = ~clk;

    spp_serial_port dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_3w (mode_3w),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .sdio_i  (sdio_i),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .sdo     (sdo),
        .bank_q  (bank_q)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int tb_bytes(input int a);
        case (a)
            0: return 4;
            1: return 3;
            2: return 4;
            3: return 2;
            4: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] tb_mask(input int nb);
        if (nb >= 4) return 32'hFFFF_FFFF;
        return (32'h1 << (nb * 8)) - 32'h1;
    endfunction

    function automatic logic [BANK_BITS-1:0] exp_bank();
        logic [BANK_BITS-1:0] e;
        int off;
        e = '0;
        off = 0;
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < tb_bytes(a) * 8; b++) e[off + b] = mdl[a][b];
            off += tb_bytes(a) * 8;
        end
        return e;
    endfunction

    task automatic sel();
        sclk = idle_hi;
        wclk(HP);
        cs_n = 1'b0;
        wclk(HP);
    endtask

    task automatic desel();
        sclk = idle_hi;
        wclk(HP);
        cs_n = 1'b1;
        wclk(4 * HP);
    endtask

    task automatic bitx(input logic b, output logic pin, output logic oe, output logic so);
        sclk   = 1'b0;
        sdio_i = b;
        wclk(HP);
        pin  = mode_3w ? sdo : sdio_o;
        oe   = sdio_oe;
        so   = sdo;
        sclk = 1'b1;
        wclk(HP);
    endtask

    // One full access; returns collected read bits and whether the pins behaved.
    task automatic xfer(input bit rd, input int addr, input logic [1:0] junk,
                        input logic [31:0] wd, output logic [31:0] rv, output bit pins_ok);
        logic [7:0] ins;
        logic p, o, s;
        int nb;
        nb = tb_bytes(addr);
        ins = {rd, junk, addr[4:0]};
        pins_ok = 1'b1;
        rv = '0;
        for (int i = 7; i >= 0; i--) begin
            bitx(ins[i], p, o, s);
            if (o !== 1'b0) pins_ok = 1'b0;
        end
        for (int i = nb * 8 - 1; i >= 0; i--) begin
            bitx(wd[i], p, o, s);
            rv[i] = p;
            if (o !== (rd && !mode_3w)) pins_ok = 1'b0;
            if (!mode_3w && s !== 1'b0) pins_ok = 1'b0;
        end
        if (!rd && addr < 5) mdl[addr] = wd & tb_mask(nb);
    endtask

    function automatic logic [31:0] exp_read(input int addr);
        if (addr < 5) return mdl[addr];
        return 32'h0;
    endfunction

    task automatic do_read(input int addr, input logic [1:0] junk, input string req);
        logic [31:0] rv;
        bit ok;
        xfer(1'b1, addr, junk, $urandom, rv, ok);
        check(rv === exp_read(addr), req, "read value", 128'(rv), 128'(exp_read(addr)));
        check(ok, req, "pin enables during read", 128'(ok), 128'(1));
    endtask

    task automatic do_write(input int addr, input logic [1:0] junk, input logic [31:0] wd,
                            input string req);
        logic [31:0] rv;
        bit ok;
        xfer(1'b0, addr, junk, wd, rv, ok);
        check(ok, req, "pins idle during write", 128'(ok), 128'(1));
    endtask

    task automatic check_bank(input string req);
        wclk(HP);
        check(bank_q === exp_bank(), req, "bank contents", 128'(bank_q), 128'(exp_bank()));
    endtask

    initial begin
        wclk(150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        bit ok;
        void'($urandom(32'd7713));
        for (int a = 0; a < 5; a++) mdl[a] = '0;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R1: reset state
        check(bank_q === '0, "R1", "bank after reset", 128'(bank_q), 128'(0));
        check(sdio_oe === 1'b0 && sdo === 1'b0, "R1", "pins after reset",
              128'({sdio_oe, sdo}), 128'(0));

        // R3 R4: 3-byte write, idle low, two-wire
        idle_hi = 1'b0; mode_3w = 1'b0;
        sel(); do_write(1, 2'b00, 32'h00A5_C33C, "R3"); desel();
        check_bank("R4");
        // R6 R7: two-wire read back
        sel(); do_read(1, 2'b00, "R6"); desel();

        // R5: chained accesses in one window
        sel();
        do_write(3, 2'b00, 32'h0000_BEEF, "R5");
        do_write(4, 2'b00, 32'h0000_1234, "R5");
        do_write(0, 2'b00, 32'hCAFE_F00D, "R5");
        do_read(3, 2'b00, "R5");
        do_read(0, 2'b00, "R5");
        desel();
        check_bank("R5");

        // R8 R11: three-wire read with clock idling high
        idle_hi = 1'b1; mode_3w = 1'b1;
        sel(); do_write(2, 2'b00, 32'h8000_0001, "R11"); do_read(2, 2'b00, "R8"); desel();
        check_bank("R11");

        // R2: bits 6:5 set must not alter the address
        mode_3w = 1'b0;
        sel(); do_write(2, 2'b11, 32'h1357_9BDF, "R2"); do_read(2, 2'b10, "R2"); desel();
        check_bank("R2");

        // R9: abort after 12 data bits of a 4-byte write
        idle_hi = 1'b0;
        sel();
        begin
            logic [7:0] ins;
            logic p, o, s;
            ins = 8'h02;
            for (int i = 7; i >= 0; i--) bitx(ins[i], p, o, s);
            for (int i = 0; i < 12; i++) bitx(1'b1, p, o, s);
        end
        desel();
        check_bank("R9");
        sel(); do_read(2, 2'b00, "R9"); desel();

        // R10: unmapped write, unmapped read, then framing still intact
        sel();
        do_write(9, 2'b00, 32'h0000_00FF, "R10");
        do_read(20, 2'b00, "R10");
        do_read(0, 2'b00, "R10");
        desel();
        check_bank("R10");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int n;
            idle_hi = 1'($urandom_range(0, 1));
            mode_3w = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 2);
            sel();
            for (int k = 0; k < n; k++) begin
                int a;
                logic [1:0] j;
                a = ($urandom_range(0, 3) == 0) ? $urandom_range(5, 31) : $urandom_range(0, 4);
                j = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 1) == 1) do_read(a, j, "R6");
                else do_write(a, j, $urandom, "R3");
            end
            desel();
            check_bank("R4");
        end

        rv = '0; ok = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule